// File: doc/BRIEF.md
# RTC Front-End Control Register Block

This block is the memory-mapped front end that sits between a processor bus and a slow serial link to a real-time-clock macro. Software can drive the three link pins (serial clock, enable, data-in) by hand through a control word, and it can read back the link's data-out line and a ready indication through a status word. A transfer of the RTC's own registers is done entirely in software by toggling those pins.

Next to the manual pin control sits a hardware auto-serializer for the 16-bit analog static configuration word. The upper byte of that word lives in its own register and the lower byte lives in the top byte of the control word. Software writes the low byte and sets a start bit in one write, then polls a busy flag. While the serializer runs, it owns the pins and shifts the word out MSB first, one bit per divided clock period. When it is done, it hands the pins back to the software values.

Top module: `rtc_front_end`

## Requirements
- R1: After reset the pins are low, offset 0x00 reads 0x0A000000 and offset 0x10 reads 0x00000018. Together these hold the static word 0x180A, which is a bias code of 5 in bits 3:1 and a voltage code of 3 in bits 12:11.
- R2: While the serializer is idle, bits 0, 1 and 2 of a write to offset 0x00 set the serial clock, enable and data-in pins on the next clock. The same bits read back at offset 0x00.
- R3: Offset 0x04 reads the data-out input in bit 0 and the ready input in bit 1. All of its other bits read 0.
- R4: Bits 31:24 of offset 0x00 hold the low byte of the static word and bits 7:0 of offset 0x10 hold its high byte. Both are writable while idle. Unused bits of both words read 0.
- R5: An idle write to offset 0x00 with bit 17 set starts the serializer. The payload is the stored high byte joined with bits 31:24 of that same write. Bit 17 always reads 0.
- R6: Busy reads as 1 in bit 22 of both offset 0x00 and offset 0x10. It lasts exactly 32 × HALF_DIV cycles, counted from the clock edge that takes the start write.
- R7: During a run the enable pin is high. The 16 payload bits go out MSB first. Each bit holds the clock low for HALF_DIV cycles and then high for HALF_DIV cycles, and data-in does not change while the clock is high.
- R8: While busy, every write to offset 0x00 or 0x10 is ignored, including pin bits, payload bytes and a second start.
- R9: When busy clears, the pins return to the values last written by software.
- R10: Offsets 0x08 and 0x0C, offsets above 0x10 and unaligned addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| rtc_sclk | output | 1 | Serial clock pin to the RTC |
| rtc_sen | output | 1 | Serial enable pin to the RTC |
| rtc_sdi | output | 1 | Serial data pin towards the RTC |
| rtc_sdo | input | 1 | Serial data pin from the RTC |
| rtc_ready | input | 1 | Ready indication from the RTC link |

## Verification
Some properties are checked by assertions on every cycle:
- each run lasts exactly 32 × HALF_DIV cycles;
- a run begins only after a start request;
- data-in is steady while the serial clock is high;
- enable stays high for the whole run;
- the software pin and payload registers stay frozen while busy.

Other behaviour can only be shown by the bench's scenarios:
- that the bits leave MSB first and make up exactly the high byte joined with the freshly written low byte;
- the reset values and the status word;
- that unmapped offsets read zero;
- that the pins return to their software values after a run.

// File: rtl/rtcfe_pkg.sv
package rtcfe_pkg;

  localparam int REG_W  = 32;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // word-aligned byte offsets
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_STAT   = 'h04;
  localparam int OFS_STATIC = 'h10;

  // control word fields
  localparam int POS_SCLK  = 0;
  localparam int POS_SEN   = 1;
  localparam int POS_SDI   = 2;
  localparam int POS_START = 17;
  localparam int POS_BUSY  = 22;
  localparam int POS_LOW   = 24;

  // status word fields
  localparam int POS_DOUT  = 0;
  localparam int POS_READY = 1;

  // analog configuration defaults
  localparam int BIAS_CODE  = 5;
  localparam int BIAS_POS   = 1;
  localparam int VOLT_CODE  = 3;
  localparam int VOLT_POS   = 11;

  typedef struct packed {
    logic sdi;
    logic sen;
    logic sclk;
  } pins_t;

  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_LOW  = 2'd1,
    SER_HIGH = 2'd2
  } ser_state_e;

  function automatic logic [WORD_W-1:0] default_static();
    return WORD_W'((BIAS_CODE << BIAS_POS) | (VOLT_CODE << VOLT_POS));
  endfunction

  function automatic int run_cycles(input int half_div);
    return 2 * half_div * WORD_W;
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input logic [BYTE_W-1:0] low,
                                                 input logic busy,
                                                 input pins_t pins);
    logic [REG_W-1:0] w;
    w = '0;
    w[POS_LOW +: BYTE_W] = low;
    w[POS_BUSY]          = busy;
    w[POS_SCLK]          = pins.sclk;
    w[POS_SEN]           = pins.sen;
    w[POS_SDI]           = pins.sdi;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic dout, input logic ready);
    logic [REG_W-1:0] w;
    w = '0;
    w[POS_DOUT]  = dout;
    w[POS_READY] = ready;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] pack_static(input logic [BYTE_W-1:0] high,
                                                   input logic busy);
    logic [REG_W-1:0] w;
    w = '0;
    w[BYTE_W-1:0] = high;
    w[POS_BUSY]   = busy;
    return w;
  endfunction

endpackage

// File: rtl/rtcfe_regs.sv
module rtcfe_regs
  import rtcfe_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [REG_W-1:0]       bus_wdata,
  output logic [REG_W-1:0]       bus_rdata,
  input  logic                   ser_busy_i,
  input  logic                   dout_i,
  input  logic                   ready_i,
  output pins_t                  sw_pins_o,
  output logic                   start_o,
  output logic [WORD_W-1:0]      load_word_o
);

  localparam logic [WORD_W-1:0] RESET_WORD = default_static();

  logic              hit_ctrl, hit_stat, hit_static;
  logic              wr_ctrl, wr_static;
  pins_t             pins_q;
  logic [BYTE_W-1:0] low_q, high_q;
  logic              wdata_unused;

  assign hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_stat   = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_static = (bus_addr == ADDR_W'(OFS_STATIC));

  // writes are dropped while the serializer owns the link
  assign wr_ctrl   = bus_wr && hit_ctrl   && !ser_busy_i;
  assign wr_static = bus_wr && hit_static && !ser_busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= '0;
      low_q  <= RESET_WORD[BYTE_W-1:0];
      high_q <= RESET_WORD[WORD_W-1:BYTE_W];
    end else begin
      if (wr_ctrl) begin
        pins_q.sclk <= bus_wdata[POS_SCLK];
        pins_q.sen  <= bus_wdata[POS_SEN];
        pins_q.sdi  <= bus_wdata[POS_SDI];
        low_q       <= bus_wdata[POS_LOW +: BYTE_W];
      end
      if (wr_static) begin
        high_q <= bus_wdata[BYTE_W-1:0];
      end
    end
  end

  assign start_o     = wr_ctrl && bus_wdata[POS_START];
  assign load_word_o = {high_q, bus_wdata[POS_LOW +: BYTE_W]};
  assign sw_pins_o   = pins_q;

  assign wdata_unused = ^{bus_wdata[23:18], bus_wdata[16:8]};

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)   bus_rdata = pack_ctrl(low_q, ser_busy_i, pins_q);
    if (hit_stat)   bus_rdata = pack_status(dout_i, ready_i);
    if (hit_static) bus_rdata = pack_static(high_q, ser_busy_i);
  end

  // R8: software state stays frozen for the whole run
  a_r8_frozen_while_busy : assert property (@(posedge clk) disable iff (!rst_n)
    (ser_busy_i && $past(ser_busy_i)) |-> ($stable(pins_q) && $stable(low_q) && $stable(high_q)))
    else $error("a_r8_frozen_while_busy");

endmodule

// File: rtl/rtcfe_bitclk.sv
module rtcfe_bitclk #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic phase_end_o
);

  generate
    if (HALF_DIV == 1) begin : g_nodiv
      assign phase_end_o = run_i;
    end else begin : g_div
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt_q;

      assign phase_end_o = run_i && (cnt_q == CW'(HALF_DIV - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (!run_i || phase_end_o) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/rtcfe_shifter.sv
module rtcfe_shifter
  import rtcfe_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              phase_end_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              sdi_o,
  output logic              done_o
);

  localparam int BCW   = $clog2(WORD_W);
  localparam int TOTAL = run_cycles(HALF_DIV);
  localparam int RCW   = $clog2(TOTAL + 1);

  ser_state_e        state_q;
  logic [WORD_W-1:0] shreg_q;
  logic [BCW-1:0]    bitcnt_q;
  logic              last_bit;

  assign last_bit = (bitcnt_q == BCW'(WORD_W - 1));
  assign done_o   = (state_q == SER_HIGH) && phase_end_i && last_bit;
  assign busy_o   = (state_q != SER_IDLE);
  assign sclk_o   = (state_q == SER_HIGH);
  assign sdi_o    = shreg_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SER_IDLE;
      shreg_q  <= '0;
      bitcnt_q <= '0;
    end else begin
      unique case (state_q)
        SER_IDLE: if (start_i) begin
          shreg_q  <= load_word_i;
          bitcnt_q <= '0;
          state_q  <= SER_LOW;
        end
        SER_LOW: if (phase_end_i) state_q <= SER_HIGH;
        SER_HIGH: if (phase_end_i) begin
          if (last_bit) begin
            state_q <= SER_IDLE;
          end else begin
            shreg_q  <= shreg_q << 1;
            bitcnt_q <= bitcnt_q + 1'b1;
            state_q  <= SER_LOW;
          end
        end
        default: state_q <= SER_IDLE;
      endcase
    end
  end

  // run-length observer for the checks below
  logic [RCW-1:0] run_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len_q <= '0;
    else if (busy_o) run_len_q <= run_len_q + 1'b1;
    else             run_len_q <= '0;
  end

  // R6: each run lasts exactly 2*HALF_DIV cycles per bit
  a_r6_run_length : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_len_q == RCW'(TOTAL)))
    else $error("a_r6_run_length");

  // R5: a run only begins after a start request
  a_r5_run_needs_start : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i))
    else $error("a_r5_run_needs_start");

  // R7: data-in held while the serial clock is high
  a_r7_sdi_held_high : assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdi_o))
    else $error("a_r7_sdi_held_high");

endmodule

// File: rtl/rtc_front_end.sv
module rtc_front_end
  import rtcfe_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int HALF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rtc_sclk,
  output logic              rtc_sen,
  output logic              rtc_sdi,
  input  logic              rtc_sdo,
  input  logic              rtc_ready
);

  pins_t             sw_pins;
  logic              start_req;
  logic [WORD_W-1:0] load_word;
  logic              ser_busy, ser_sclk, ser_sdi, ser_done;
  logic              phase_end;

  rtcfe_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .ser_busy_i  (ser_busy),
    .dout_i      (rtc_sdo),
    .ready_i     (rtc_ready),
    .sw_pins_o   (sw_pins),
    .start_o     (start_req),
    .load_word_o (load_word)
  );

  rtcfe_bitclk #(.HALF_DIV(HALF_DIV)) i_bitclk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (ser_busy),
    .phase_end_o (phase_end)
  );

  rtcfe_shifter #(.HALF_DIV(HALF_DIV)) i_shifter (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_req),
    .load_word_i (load_word),
    .phase_end_i (phase_end),
    .busy_o      (ser_busy),
    .sclk_o      (ser_sclk),
    .sdi_o       (ser_sdi),
    .done_o      (ser_done)
  );

  // pin ownership: serializer while busy, software otherwise
  assign rtc_sclk = ser_busy ? ser_sclk : sw_pins.sclk;
  assign rtc_sen  = ser_busy ? 1'b1     : sw_pins.sen;
  assign rtc_sdi  = ser_busy ? ser_sdi  : sw_pins.sdi;

  // R7: enable asserted for the whole run
  a_r7_enable_during_run : assert property (@(posedge clk) disable iff (!rst_n)
    ser_busy |-> rtc_sen)
    else $error("a_r7_enable_during_run");

  // R6: completion pulse ends the run on the next edge
  a_r6_done_ends_run : assert property (@(posedge clk) disable iff (!rst_n)
    ser_done |=> !ser_busy)
    else $error("a_r6_done_ends_run");

endmodule

// File: tb/test_rtc_front_end.sv
module test_rtc_front_end;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 4;
  localparam int ADDR_W     = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              rtc_sclk, rtc_sen, rtc_sdi;
  logic              rtc_sdo = 1'b0;
  logic              rtc_ready = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  rtc_front_end #(.ADDR_W(ADDR_W), .HALF_DIV(HALF_DIV)) i_rtc_front_end (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rtc_sclk(rtc_sclk),
    .rtc_sen(rtc_sen), .rtc_sdi(rtc_sdi), .rtc_sdo(rtc_sdo), .rtc_ready(rtc_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected-value model
  function automatic logic [31:0] exp_ctrl(input logic [7:0] lo, input logic busy,
                                           input logic [2:0] pins);
    return ({24'd0, lo} << 24) + (busy ? 32'h0040_0000 : 32'd0) + {29'd0, pins};
  endfunction

  function automatic logic [31:0] exp_static(input logic [7:0] hi, input logic busy);
    return {24'd0, hi} | (busy ? 32'h0040_0000 : 32'd0);
  endfunction

  function automatic int exp_run_len();
    return HALF_DIV * 2 * 16;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    #1 d = bus_rdata;
  endtask

  logic [7:0] cur_lo, cur_hi;
  logic [2:0] cur_pins;

  task automatic run_serial(input logic [7:0] hi, input logic [7:0] lo, input logic [2:0] pins);
    logic [31:0] rd;
    logic [15:0] word;
    int cnt, nbits, sen_bad, hold_bad, i;
    logic prev_sclk, prev_sdi, busy;
    bus_write(5'h10, {24'd0, hi});
    bus_write(5'h00, ({24'd0, lo} << 24) | 32'h0002_0000 | {29'd0, pins});
    cur_hi = hi; cur_lo = lo; cur_pins = pins;
    cnt = 0; nbits = 0; sen_bad = 0; hold_bad = 0; word = '0;
    prev_sclk = 1'b0; prev_sdi = 1'b0; i = 0;
    busy = 1'b1;
    while (busy) begin
      bus_wr = 1'b0; bus_addr = 5'h00;
      if (i == 2) begin  // R8: rewrite ctrl with a second start
        bus_wr = 1'b1; bus_addr = 5'h00;
        bus_wdata = ({24'd0, ~lo} << 24) | 32'h0002_0000 | {29'd0, ~pins};
      end
      if (i == 3) begin  // R8: rewrite static high byte
        bus_wr = 1'b1; bus_addr = 5'h10; bus_wdata = {24'd0, ~hi};
      end
      #1;
      busy = bus_rdata[22];  // R6: busy visible at 0x00 and 0x10
      if (busy) begin
        cnt++;
        if (rtc_sen !== 1'b1) sen_bad++;
        if (rtc_sclk && !prev_sclk) begin
          word = {word[14:0], rtc_sdi};
          nbits++;
        end
        if (rtc_sclk && prev_sclk && (rtc_sdi !== prev_sdi)) hold_bad++;
        prev_sclk = rtc_sclk; prev_sdi = rtc_sdi;
        i++;
        @(negedge clk);
      end
      if (cnt > 10 * exp_run_len()) busy = 1'b0;
    end
    chk("R6 busy length", cnt, exp_run_len());
    chk("R7 bit count", nbits, 16);
    chk("R7 MSB-first payload", {16'd0, word}, {16'd0, hi, lo});
    chk("R7 enable high during run", sen_bad, 0);
    chk("R7 data held while clock high", hold_bad, 0);
    chk("R9 pins released", {29'd0, rtc_sdi, rtc_sen, rtc_sclk}, {29'd0, pins});
    bus_read(5'h00, rd);
    chk("R8 ctrl unchanged by busy writes", rd, exp_ctrl(lo, 1'b0, pins));
    bus_read(5'h10, rd);
    chk("R8 static unchanged by busy writes", rd, exp_static(hi, 1'b0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, w;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(5'h00, rd); chk("R1 ctrl reset", rd, 32'h0A00_0000);
    bus_read(5'h10, rd); chk("R1 static reset", rd, 32'h0000_0018);
    chk("R1 pins reset", {29'd0, rtc_sdi, rtc_sen, rtc_sclk}, 32'd0);
    cur_lo = 8'h0A; cur_hi = 8'h18; cur_pins = 3'b000;

    // R3 status word
    for (int k = 0; k < 4; k++) begin
      rtc_sdo = k[0]; rtc_ready = k[1];
      bus_read(5'h04, rd);
      chk("R3 status", rd, {30'd0, k[1], k[0]});
    end

    // R2 / R4 pin and byte writes with random background bits (start bit cleared)
    for (int k = 0; k < 8; k++) begin
      w = $urandom & ~32'h0002_0000;
      bus_write(5'h00, w);
      cur_pins = w[2:0]; cur_lo = w[31:24];
      @(negedge clk);
      chk("R2 pins follow ctrl", {29'd0, rtc_sdi, rtc_sen, rtc_sclk}, {29'd0, cur_pins});
      bus_read(5'h00, rd);
      chk("R2/R4 ctrl readback", rd, exp_ctrl(cur_lo, 1'b0, cur_pins));
    end
    for (int k = 0; k < 4; k++) begin
      w = $urandom;
      bus_write(5'h10, w);
      cur_hi = w[7:0];
      bus_read(5'h10, rd);
      chk("R4 static readback", rd, exp_static(cur_hi, 1'b0));
    end

    // R10 unmapped and unaligned offsets
    begin
      logic [ADDR_W-1:0] holes [6] = '{5'h08, 5'h0C, 5'h14, 5'h01, 5'h12, 5'h1C};
      foreach (holes[k]) begin
        bus_write(holes[k], 32'hFFFF_FFFF);
        bus_read(holes[k], rd);
        chk("R10 hole reads zero", rd, 32'd0);
      end
      bus_read(5'h00, rd); chk("R10 ctrl untouched", rd, exp_ctrl(cur_lo, 1'b0, cur_pins));
      bus_read(5'h10, rd); chk("R10 static untouched", rd, exp_static(cur_hi, 1'b0));
    end

    // R5-R9 auto-serializer runs: directed corners then random
    run_serial(8'h18, 8'h0A, 3'b000);
    run_serial(8'h80, 8'h01, 3'b101);
    run_serial(8'hFF, 8'hFF, 3'b010);
    run_serial(8'h00, 8'h00, 3'b111);
    for (int k = 0; k < 4; k++) begin
      w = $urandom;
      run_serial(w[15:8], w[7:0], w[18:16]);
    end
    bus_read(5'h00, rd);
    chk("R5 start bit reads zero", {31'd0, rd[17]}, 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule